// File: doc/BRIEF.md
# Partitioned Byte-by-Halfword Multiplier

This block is a SIMD multiplier on 64-bit words. It multiplies 8-bit pixel components by 16-bit signed scale factors across four lanes and rounds each product. Results come back either as four 16-bit lanes or as two 32-bit lanes. A 3-bit mode input selects one of seven variants. The variants differ in where the byte factor and the halfword factor are taken from in the two operands, and in the width of the result lanes.

Every variant uses the same rounding step. The signed product is formed as a 32-bit two's-complement value. If its least significant byte is above 0x7F, 0x100 is added. A 16-bit lane keeps bits [23:8] of that value, and a 32-bit lane keeps all of it.

The result and the output valid are registered. A request that is presented together with `in_valid` at one rising edge appears at the outputs straight after that edge.

Top module: `pbh_mul`

## Requirements
- R1: `out_valid` is high in the cycle after each edge at which `in_valid` was high, and low after each edge at which it was low. Synchronous active-low reset clears `out_valid` and `result` to zero.
- R2: While `in_valid` is low, `result` keeps its last value whatever `mode`, `op_a` and `op_b` do.
- R3: Each lane forms a 32-bit signed product. If bits [7:0] of the product are 0x80 or higher, 0x100 is added. A 16-bit lane returns bits [23:8] of the adjusted value.
- R4: In mode 0, lane r (r = 0..3) multiplies unsigned byte r of `op_a` (bits [8r+7:8r]) by signed halfword r of `op_b` (bits [16r+15:16r]). It writes the rounded 16-bit result to `result[16r+15:16r]`, and lane 0 is the least significant.
- R5: Mode 1 is like mode 0, but every lane uses signed halfword 1 of `op_b` (bits [31:16]). Mode 2 is also like mode 0, but every lane uses signed halfword 0 (bits [15:0]).
- R6: In mode 3, the byte factor of lane r is signed halfword r of `op_a` shifted right arithmetically by 8, which is its upper byte taken as signed. It is multiplied by signed halfword r of `op_b` and gives a 16-bit lane.
- R7: In mode 4, the byte factor of lane r is unsigned byte 2r of `op_a`, which is the low byte of halfword r. It is multiplied by signed halfword r of `op_b` and gives a 16-bit lane.
- R8: Modes 5 and 6 take their factors as modes 3 and 4 do, but only for lanes 0 and 1. Each writes the whole 32-bit adjusted product into `result[32r+31:32r]`. Halfwords 2 and 3 of both operands have no effect.
- R9: Mode 7 returns a `result` of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| mode | input | 3 | Variant select, codes 0 to 7 |
| op_a | input | 64 | Operand holding the byte factors |
| op_b | input | 64 | Operand holding the halfword factors |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| result | output | 64 | Packed lane results |

## Verification
Each result and its `out_valid` are due one clock edge after the edge that samples the request. The bench sets the inputs on a falling edge and waits for the next rising edge. It then samples one nanosecond later, so it reads the register that was just loaded and nothing else. After that it drops `in_valid` and checks, at the edges that follow, that `out_valid` has fallen and `result` has not moved. Computed results are compared against hand-derived values at the 0x7F/0x80 rounding boundary and against a reference function over random operands in every mode.

// File: rtl/pbh_pkg.sv
// Package for the partitioned byte-by-halfword multiplier.
// Holds the mode encoding that the operand selector and the result merger both decode.
package pbh_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_LANE     = 3'd0,  // byte r x halfword r
        PM_BC_HI    = 3'd1,  // byte r x halfword 1
        PM_BC_LO    = 3'd2,  // byte r x halfword 0
        PM_UPPER    = 3'd3,  // signed upper byte of a-halfword r x halfword r
        PM_LOWER    = 3'd4,  // unsigned low byte of a-halfword r x halfword r
        PM_W_UPPER  = 3'd5,  // as PM_UPPER, full 32-bit lanes 0..1
        PM_W_LOWER  = 3'd6,  // as PM_LOWER, full 32-bit lanes 0..1
        PM_RSVD     = 3'd7   // undefined, returns zero
    } pbh_mode_e;

endpackage

// File: rtl/pbh_opsel.sv
// Factor selector for one lane.
// Chooses the byte factor (extended by one bit to signed) and the signed halfword
// factor from the operand slices that belong to this lane, as the mode asks.
// Assumes the halfword width is twice the byte width.
module pbh_opsel
    import pbh_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int SCL_W = 16
) (
    input  logic [MODE_W-1:0]       mode,
    input  logic [PIX_W-1:0]        a_byte,   // byte r of operand a
    input  logic [SCL_W-1:0]        a_half,   // halfword r of operand a
    input  logic [SCL_W-1:0]        b_half,   // halfword r of operand b
    input  logic [SCL_W-1:0]        b_h0,     // halfword 0 of operand b
    input  logic [SCL_W-1:0]        b_h1,     // halfword 1 of operand b
    output logic signed [PIX_W:0]   pix_f,
    output logic signed [SCL_W-1:0] scl_f
);

    // Signed view of the upper byte and zero-extended view of the low byte of a_half
    logic signed [PIX_W:0] up_byte;
    logic signed [PIX_W:0] lo_byte;
    logic signed [PIX_W:0] ln_byte;

    assign up_byte = {a_half[SCL_W-1], a_half[SCL_W-1 -: PIX_W]};
    assign lo_byte = {1'b0, a_half[PIX_W-1:0]};
    assign ln_byte = {1'b0, a_byte};

    // Byte factor choice by mode
    always_comb begin
        unique case (pbh_mode_e'(mode))
            PM_LANE, PM_BC_HI, PM_BC_LO: pix_f = ln_byte;
            PM_UPPER, PM_W_UPPER:        pix_f = up_byte;
            PM_LOWER, PM_W_LOWER:        pix_f = lo_byte;
            default:                     pix_f = '0;
        endcase
    end

    // Halfword factor choice by mode
    always_comb begin
        unique case (pbh_mode_e'(mode))
            PM_BC_HI: scl_f = b_h1;
            PM_BC_LO: scl_f = b_h0;
            default:  scl_f = b_half;
        endcase
    end

endmodule

// File: rtl/pbh_lane_mul.sv
// One lane multiplier with the shared rounding step.
// Forms the signed product at twice the halfword width. When the bit just below
// the byte boundary is set, it adds one unit of the byte boundary. Returns
// the adjusted value and its scaled halfword slice. Purely combinational.
module pbh_lane_mul #(
    parameter int PIX_W = 8,
    parameter int SCL_W = 16
) (
    input  logic signed [PIX_W:0]   pix_f,
    input  logic signed [SCL_W-1:0] scl_f,
    output logic [SCL_W-1:0]        res_n,
    output logic [2*SCL_W-1:0]      res_w
);

    localparam int PROD_W = 2 * SCL_W;
    localparam logic [PROD_W-1:0] RND_INC =
        {{(PROD_W-PIX_W-1){1'b0}}, 1'b1, {PIX_W{1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic [PROD_W-1:0]        adj;

    // Signed product at full lane width
    assign prod = PROD_W'(pix_f) * PROD_W'(scl_f);

    // Low byte above half scale rounds the kept slice up
    assign adj = prod[PIX_W-1] ? (prod + RND_INC) : prod;

    assign res_w = adj;
    assign res_n = adj[PIX_W+SCL_W-1:PIX_W];

endmodule

// File: rtl/pbh_merge.sv
// Result merger.
// Packs either all narrow lane results or the wide results of the lower lanes
// into the output word, or returns zero for the undefined mode.
module pbh_merge
    import pbh_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] narrow,
    input  logic [DATA_W-1:0] wide,
    output logic [DATA_W-1:0] merged
);

    // Output word choice by result width of the mode
    always_comb begin
        unique case (pbh_mode_e'(mode))
            PM_LANE, PM_BC_HI, PM_BC_LO, PM_UPPER, PM_LOWER: merged = narrow;
            PM_W_UPPER, PM_W_LOWER:                          merged = wide;
            default:                                         merged = '0;
        endcase
    end

endmodule

// File: rtl/pbh_mul.sv
// Partitioned byte-by-halfword multiplier, top level.
// Builds one selector and one multiplier per lane. The lower half of the lanes
// also feeds the wide result. The merged word and its valid are registered once.
// Assumes LANE_CNT is even and SCL_W is twice PIX_W. Reset is synchronous, active low.
module pbh_mul
    import pbh_pkg::*;
#(
    parameter int LANE_CNT = 4,
    parameter int PIX_W    = 8,
    parameter int SCL_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [MODE_W-1:0]           mode,
    input  logic [LANE_CNT*SCL_W-1:0]   op_a,
    input  logic [LANE_CNT*SCL_W-1:0]   op_b,
    output logic                        out_valid,
    output logic [LANE_CNT*SCL_W-1:0]   result
);

    localparam int DATA_W   = LANE_CNT * SCL_W;
    localparam int PROD_W   = 2 * SCL_W;
    localparam int WIDE_CNT = LANE_CNT / 2;

    logic [DATA_W-1:0]   narrow;
    logic [DATA_W-1:0]   wide;
    logic [DATA_W-1:0]   merged;
    logic [LANE_CNT-1:0] unused_wide;

    genvar r;
    generate
        for (r = 0; r < LANE_CNT; r++) begin : g_lane
            logic signed [PIX_W:0]   pix_f;
            logic signed [SCL_W-1:0] scl_f;
            logic [PROD_W-1:0]       res_w;

            pbh_opsel #(.PIX_W(PIX_W), .SCL_W(SCL_W)) u_sel (
                .mode   (mode),
                .a_byte (op_a[r*PIX_W +: PIX_W]),
                .a_half (op_a[r*SCL_W +: SCL_W]),
                .b_half (op_b[r*SCL_W +: SCL_W]),
                .b_h0   (op_b[0 +: SCL_W]),
                .b_h1   (op_b[SCL_W +: SCL_W]),
                .pix_f  (pix_f),
                .scl_f  (scl_f)
            );

            pbh_lane_mul #(.PIX_W(PIX_W), .SCL_W(SCL_W)) u_mul (
                .pix_f (pix_f),
                .scl_f (scl_f),
                .res_n (narrow[r*SCL_W +: SCL_W]),
                .res_w (res_w)
            );

            // Lower lanes drive the wide word, upper lanes only the narrow one
            if (r < WIDE_CNT) begin : g_wide
                assign wide[r*PROD_W +: PROD_W] = res_w;
                assign unused_wide[r] = 1'b0;
            end else begin : g_nowide
                assign unused_wide[r] = ^res_w;
            end
        end
    endgenerate

    pbh_merge #(.DATA_W(DATA_W)) u_merge (
        .mode   (mode),
        .narrow (narrow),
        .wide   (wide),
        .merged (merged)
    );

    // Valid follows the request by one edge
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result loads on a request and holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= merged;
    end

endmodule

// File: rtl/pbh_mul_chk.sv
// Checker for the multiplier's port-level timing and the zero results.
// Bound to every instance of the top module.
module pbh_mul_chk #(
    parameter int DATA_W = 64,
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [MODE_W-1:0] mode,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_zero_pix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == '0 && op_a == '0) |=> result == '0);

    p_zero_scale_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_W'(5) && op_b == '0) |=> result == '0);

    p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_W'(7)) |=> result == '0);

endmodule

bind pbh_mul pbh_mul_chk #(.DATA_W(LANE_CNT*SCL_W), .MODE_W(pbh_pkg::MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_pbh_mul.sv
// Directed bench for the partitioned multiplier; one task per scenario.
module tb_pbh_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    pbh_mul dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result)
    );

    // Reference function written from the requirements
    function automatic logic [63:0] model(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) begin
            int f8;
            int s16;
            int p;
            logic [31:0] t;
            s16 = $signed(b[16*k +: 16]);
            if (m == 3'd1) s16 = $signed(b[31:16]);
            if (m == 3'd2) s16 = $signed(b[15:0]);
            case (m)
                3'd0, 3'd1, 3'd2: f8 = int'(a[8*k +: 8]);
                3'd3, 3'd5:       f8 = $signed(a[16*k+8 +: 8]);
                3'd4, 3'd6:       f8 = int'(a[16*k +: 8]);
                default:          f8 = 0;
            endcase
            p = s16 * f8;
            t = p;
            if (t[7:0] > 8'h7F) t = t + 32'h100;
            if (m <= 3'd4) r[16*k +: 16] = t[23:8];
            else if (m <= 3'd6 && k < 2) r[32*k +: 32] = t;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Present one request, sample just after the loading edge
    task automatic issue(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        mode = m; op_a = a; op_b = b; in_valid = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_check(input string req, input logic [2:0] m,
                             input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
        issue(m, a, b);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, result, exp);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_lane();
        run_check("R4", 3'd0, 64'h0000_0000_FF80_0201, 64'h7FFF_FF00_0200_0100, 64'h7F7F_FF80_0004_0001);
    endtask

    task automatic t_bcast();
        run_check("R5 hi", 3'd1, 64'h0000_0000_FF80_0201, 64'h1111_2222_0300_0100, 64'h02FD_0180_0006_0003);
        run_check("R5 lo", 3'd2, 64'h0000_0000_FF80_0201, 64'h1111_2222_0300_0100, 64'h00FF_0080_0002_0001);
    endtask

    task automatic t_upper_lower();
        run_check("R6", 3'd3, 64'h7F00_FF00_0112_80FF, 64'hFFFF_0080_0180_0100, 64'h0000_0000_0002_FF80);
        run_check("R7", 3'd4, 64'h7F00_FF00_0112_80FF, 64'hFFFF_0080_0180_0100, 64'h0000_0000_001B_00FF);
    endtask

    task automatic t_wide();
        run_check("R8 upper", 3'd5, 64'h7F00_FF00_0112_80FF, 64'hFFFF_0080_0180_0100, 64'h0000_0280_FFFF_8000);
        run_check("R8 lower", 3'd6, 64'h7F00_FF00_0112_80FF, 64'hFFFF_0080_0180_0100, 64'h0000_1B00_0000_FF00);
        // upper halfwords of both operands must not matter
        run_check("R8 ignore", 3'd6, 64'hABCD_1234_0112_80FF, 64'h5A5A_C3C3_0180_0100, 64'h0000_1B00_0000_FF00);
    endtask

    task automatic t_round();
        run_check("R3 narrow", 3'd0, 64'h0000_0000_0101_0101, 64'hFF80_FF7F_0180_017F, 64'h0000_FFFF_0002_0001);
        run_check("R3 wide", 3'd6, 64'h0000_0000_0001_0001, 64'h0000_0000_0180_017F, 64'h0000_0280_0000_017F);
    endtask

    task automatic t_undef();
        run_check("R4 prior", 3'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001);
        run_check("R9", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, 64'd0);
    endtask

    task automatic t_hold();
        run_check("R2 load", 3'd1, 64'h0000_0000_FF80_0201, 64'h1111_2222_0300_0100, 64'h02FD_0180_0006_0003);
        for (int i = 0; i < 3; i++) begin
            mode = 3'(i + 3); op_a = 64'h0123_4567_89AB_CDEF; op_b = ~op_a;
            @(posedge clk);
            #1;
            check("R1 idle valid", {63'd0, out_valid}, 64'd0);
            check("R2 hold", result, 64'h02FD_0180_0006_0003);
            @(negedge clk);
        end
    endtask

    task automatic t_random();
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 30; i++) begin
                logic [63:0] a;
                logic [63:0] b;
                a = {$urandom, $urandom};
                b = {$urandom, $urandom};
                if (i == 0) begin a = 64'h7F7F_7F7F_7F7F_7F7F; b = 64'h0080_0080_0080_0080; end
                if (i == 1) begin a = 64'h8080_8080_8080_8080; b = 64'h8000_7FFF_8000_7FFF; end
                run_check(m == 7 ? "R9 rand" : (m >= 5 ? "R8 rand" : "R3 rand"),
                          3'(m), a, b, model(3'(m), a, b));
            end
        end
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_lane();
        t_bcast();
        t_upper_lower();
        t_wide();
        t_round();
        t_undef();
        t_hold();
        t_random();
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule